// File: doc/BRIEF.md
# I/O Window Data Masking Unit

The unit sits on the data path between a plug-in card and a host I/O bus. It holds two programmable I/O address windows, each given by an inclusive lower and upper bound and a per-window enable. Each window also has its own 8-bit mask. A host read whose address falls in an enabled window is a card hit: card read data is passed to the host, but every low-byte bit whose mask bit is 1 is left undriven. A window with a nonzero mask also narrows the access to 8 bits. The upper byte is then not driven, and a width-force output is raised for the host bus sizing logic.

The typical use is to let two cards or functions share an I/O port. One window covers a single shared address and masks off the bits that belong to another device. The second window covers the neighbouring range with full-width drive. When both windows contain an address, window 0 wins. The bounds, masks and enables are loaded through a small synchronous register write port. The drive enables are combinational from the address, the strobes and the stored configuration.

Top module: `iowin_unit`

## Requirements
- R1: After reset all bounds are 0000h, both masks are 00h and both windows are disabled, so no access produces a card hit and no drive enable is set.
- R2: A window matches an address A when lower <= A <= upper, both bounds included. Equal bounds match exactly one address, and addresses just outside either bound do not match.
- R3: A window whose enable bit is 0 never matches. Enable register bit 0 controls window 0 and bit 1 controls window 1.
- R4: On a read (io_rd=1) hitting a window with nonzero mask M, host_rdata_oe[7:0] equals the bitwise inverse of M and host_rdata_oe[15:8] is 0. host_rdata always equals card_rdata.
- R5: On a read hitting a window whose mask is 00h, all 16 bits of host_rdata_oe are 1 and force_8bit is 0.
- R6: force_8bit is 1 exactly when card_hit is 1 and the governing window's mask is nonzero.
- R7: When an address lies in both enabled windows, window 0's mask and width rule apply.
- R8: Each mask acts only on its own window. With window 0 at 3F7h..3F7h, mask 7Fh, and window 1 at 3F0h..3F6h, mask 00h, a read of 3F7h drives only bit 7 and a read of 3F3h drives all 16 bits.
- R9: With no strobe, or with an address outside every enabled window, card_hit and force_8bit are 0 and no drive enable is set.
- R10: On a write (io_wr=1, io_rd=0) that hits, card_wdata equals host_wdata and card_wdata_oe is FFFFh, or 00FFh when force_8bit is 1. No write enables are set during a read.
- R11: A configuration write with cfg_we=1 at a clock edge loads the selected register, and the outputs use the new value from that edge onward. Selector codes: 0 = window 0 lower, 1 = window 0 upper, 2 = window 1 lower, 3 = window 1 upper, 4 = mask 0, 5 = mask 1, 6 = enables. Masks take cfg_wdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register selector |
| cfg_wdata | input | 16 | Configuration write data |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| card_rdata | input | 16 | Data from the card |
| host_rdata | output | 16 | Read data toward the host |
| host_rdata_oe | output | 16 | Per-bit drive enables for host_rdata |
| host_wdata | input | 16 | Write data from the host |
| card_wdata | output | 16 | Write data toward the card |
| card_wdata_oe | output | 16 | Per-bit drive enables for card_wdata |
| card_hit | output | 1 | Access strobe is active in an enabled window |
| force_8bit | output | 1 | Access is narrowed to 8 bits |

## Verification
The masking is tried on the shared-port layout, a one-address window with mask 7Fh next to a full-width range. This shows whether a mask leaks into the neighbouring window. An address sweep across both window edges separates inclusive from exclusive bound compares. Overlapping windows with different masks show which window governs. Toggling the enables and swapping reads for writes separates the enable gating, the write-width path and the read-only scope of the mask.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // Selector layout: per window a lower and an upper bound, then the masks,
  // then one enable register holding one bit per window.
  function automatic int sel_lo(input int k);
    return 2 * k;
  endfunction
  function automatic int sel_hi(input int k);
    return 2 * k + 1;
  endfunction
  function automatic int sel_mask(input int nwin, input int k);
    return 2 * nwin + k;
  endfunction
  function automatic int sel_en(input int nwin);
    return 3 * nwin;
  endfunction
endpackage

// File: rtl/iowin_cfg.sv
module iowin_cfg
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 16,
  parameter int MASK_W  = 8,
  parameter int SEL_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [SEL_W-1:0]                 cfg_sel,
  input  logic [ADDR_W-1:0]                cfg_wdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lo,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_hi,
  output logic [NUM_WIN-1:0][MASK_W-1:0]   win_mask,
  output logic [NUM_WIN-1:0]               win_en
);
  localparam logic [SEL_W-1:0] EN_CODE = SEL_W'(sel_en(NUM_WIN));

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [SEL_W-1:0] LO_CODE = SEL_W'(sel_lo(k));
    localparam logic [SEL_W-1:0] HI_CODE = SEL_W'(sel_hi(k));
    localparam logic [SEL_W-1:0] MK_CODE = SEL_W'(sel_mask(NUM_WIN, k));

    always_ff @(posedge clk) begin
      if (rst) begin
        win_lo[k]   <= '0;
        win_hi[k]   <= '0;
        win_mask[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == LO_CODE) win_lo[k]   <= cfg_wdata;
        if (cfg_sel == HI_CODE) win_hi[k]   <= cfg_wdata;
        if (cfg_sel == MK_CODE) win_mask[k] <= cfg_wdata[MASK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en <= '0;
    end else if (cfg_we && cfg_sel == EN_CODE) begin
      win_en <= cfg_wdata[NUM_WIN-1:0];
    end
  end
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    in_win   = en && above_lo && below_hi;
  end
endmodule

// File: rtl/iowin_route.sv
module iowin_route #(
  parameter int NUM_WIN = 2,
  parameter int DATA_W  = 16,
  parameter int MASK_W  = 8
) (
  input  logic [NUM_WIN-1:0]               hit_vec,
  input  logic [NUM_WIN-1:0][MASK_W-1:0]   win_mask,
  input  logic                             io_rd,
  input  logic                             io_wr,
  input  logic [DATA_W-1:0]                card_rdata,
  input  logic [DATA_W-1:0]                host_wdata,
  output logic [DATA_W-1:0]                host_rdata,
  output logic [DATA_W-1:0]                host_rdata_oe,
  output logic [DATA_W-1:0]                card_wdata,
  output logic [DATA_W-1:0]                card_wdata_oe,
  output logic                             card_hit,
  output logic                             force_8bit
);
  logic              any_hit;
  logic [MASK_W-1:0] sel_mask;
  logic              access;
  logic              narrow;
  logic              rd_go;
  logic              wr_go;

  // Lowest-numbered hit governs; scanning downward leaves it last-assigned.
  always_comb begin
    any_hit  = 1'b0;
    sel_mask = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        any_hit  = 1'b1;
        sel_mask = win_mask[k];
      end
    end
  end

  always_comb begin
    access = any_hit && (io_rd || io_wr);
    narrow = access && (|sel_mask);
    rd_go  = access && io_rd;
    wr_go  = access && io_wr && !io_rd;
    for (int b = 0; b < DATA_W; b++) begin
      if (b < MASK_W) begin
        host_rdata_oe[b] = rd_go && !(narrow && sel_mask[b]);
        card_wdata_oe[b] = wr_go;
      end else begin
        host_rdata_oe[b] = rd_go && !narrow;
        card_wdata_oe[b] = wr_go && !narrow;
      end
    end
    host_rdata = card_rdata;
    card_wdata = host_wdata;
    card_hit   = access;
    force_8bit = narrow;
  end
endmodule

// File: rtl/iowin_unit.sv
module iowin_unit #(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int MASK_W  = 8,
  localparam int SEL_W  = $clog2(3 * NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] card_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] host_rdata_oe,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] card_wdata,
  output logic [DATA_W-1:0] card_wdata_oe,
  output logic              card_hit,
  output logic              force_8bit
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_lo;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_hi;
  logic [NUM_WIN-1:0][MASK_W-1:0] win_mask;
  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0]             hit_vec;

  iowin_cfg #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_lo(win_lo), .win_hi(win_hi),
    .win_mask(win_mask), .win_en(win_en)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_match
    iowin_match #(.ADDR_W(ADDR_W)) u_match (
      .en(win_en[k]), .lo(win_lo[k]), .hi(win_hi[k]),
      .addr(io_addr), .in_win(hit_vec[k])
    );
  end

  iowin_route #(
    .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .MASK_W(MASK_W)
  ) u_route (
    .hit_vec(hit_vec), .win_mask(win_mask), .io_rd(io_rd), .io_wr(io_wr),
    .card_rdata(card_rdata), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .card_wdata(card_wdata), .card_wdata_oe(card_wdata_oe),
    .card_hit(card_hit), .force_8bit(force_8bit)
  );
endmodule

// File: rtl/iowin_chk.sv
module iowin_chk #(
  parameter int DATA_W = 16,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_rd,
  input logic [DATA_W-1:0] host_rdata_oe,
  input logic [DATA_W-1:0] card_wdata_oe,
  input logic              card_hit,
  input logic              force_8bit
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !card_hit);

  p_narrow_upper_off_r4: assert property (@(posedge clk) disable iff (rst)
    (force_8bit && io_rd) |-> (host_rdata_oe[DATA_W-1:MASK_W] == '0));

  p_full_width_r5: assert property (@(posedge clk) disable iff (rst)
    (card_hit && io_rd && !force_8bit) |-> (&host_rdata_oe));

  p_force_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    force_8bit |-> card_hit);

  p_quiet_outside_r9: assert property (@(posedge clk) disable iff (rst)
    !card_hit |-> (host_rdata_oe == '0 && card_wdata_oe == '0 && !force_8bit));

  p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
    !((|host_rdata_oe) && (|card_wdata_oe)));
endmodule

bind iowin_unit iowin_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .io_rd(io_rd), .host_rdata_oe(host_rdata_oe),
  .card_wdata_oe(card_wdata_oe), .card_hit(card_hit), .force_8bit(force_8bit)
);

// File: tb/test_iowin_unit.sv
module test_iowin_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] card_rdata = 16'hA5C3;
  logic [15:0] host_wdata = 16'h3C5A;
  logic [15:0] host_rdata, host_rdata_oe, card_wdata, card_wdata_oe;
  logic        card_hit, force_8bit;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // reference state
  int       m_lo[2];
  int       m_hi[2];
  bit [7:0] m_mask[2];
  bit [1:0] m_en;

  always #4 clk = ~clk;

  iowin_unit i_iowin_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .card_rdata(card_rdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .host_wdata(host_wdata),
    .card_wdata(card_wdata), .card_wdata_oe(card_wdata_oe),
    .card_hit(card_hit), .force_8bit(force_8bit)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_lo = '{0, 0}; m_hi = '{0, 0}; m_mask = '{8'h00, 8'h00}; m_en = 2'b00;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: m_lo[0] = cfg_wdata;
        3'd1: m_hi[0] = cfg_wdata;
        3'd2: m_lo[1] = cfg_wdata;
        3'd3: m_hi[1] = cfg_wdata;
        3'd4: m_mask[0] = cfg_wdata[7:0];
        3'd5: m_mask[1] = cfg_wdata[7:0];
        3'd6: m_en = cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  function automatic int gov_win();
    for (int k = 0; k < 2; k++)
      if (m_en[k] && int'(io_addr) >= m_lo[k] && int'(io_addr) <= m_hi[k]) return k;
    return -1;
  endfunction

  function automatic bit e_hit();
    return gov_win() >= 0 && (io_rd || io_wr);
  endfunction

  function automatic bit e_force();
    return e_hit() && m_mask[gov_win()] != 8'h00;
  endfunction

  function automatic [15:0] e_roe();
    if (!e_hit() || !io_rd) return 16'h0000;
    if (e_force()) return {8'h00, ~m_mask[gov_win()]};
    return 16'hFFFF;
  endfunction

  function automatic [15:0] e_woe();
    if (!e_hit() || !io_wr || io_rd) return 16'h0000;
    return e_force() ? 16'h00FF : 16'hFFFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every clock, between edge and next input change
  always @(posedge clk) begin
    #3;
    if (!rst && !done) begin
      chk("R9 model card_hit", card_hit, e_hit());
      chk("R6 model force_8bit", force_8bit, e_force());
      chk("R4 model host_rdata_oe", host_rdata_oe, e_roe());
      chk("R10 model card_wdata_oe", card_wdata_oe, e_woe());
      chk("R4 model host_rdata", host_rdata, card_rdata);
      chk("R10 model card_wdata", card_wdata, host_wdata);
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr;
    card_rdata = card_rdata ^ {a[7:0], a[15:8]};
    host_wdata = host_wdata + 16'h1357;
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state; window 0 spans 0000h..0000h but is disabled
    acc(16'h0000, 1, 0);
    chk("R1 card_hit after reset", card_hit, 0);
    chk("R1 host_rdata_oe after reset", host_rdata_oe, 16'h0000);
    chk("R1 force_8bit after reset", force_8bit, 0);

    cfg(3'd0, 16'h03F7); cfg(3'd1, 16'h03F7);
    cfg(3'd2, 16'h03F0); cfg(3'd3, 16'h03F6);
    cfg(3'd4, 16'h007F);
    acc(16'h03F7, 1, 0);
    chk("R3 disabled window no hit", card_hit, 0);
    cfg(3'd6, 16'h0003);
    acc(16'h03F7, 1, 0);
    chk("R11 enable takes effect", card_hit, 1);
    chk("R8 3F7h drives only bit 7", host_rdata_oe, 16'h0080);
    chk("R6 force on masked window", force_8bit, 1);
    chk("R4 read data passes", host_rdata, card_rdata);
    acc(16'h03F3, 1, 0);
    chk("R8 3F3h drives all bits", host_rdata_oe, 16'hFFFF);
    chk("R5 zero mask no force", force_8bit, 0);
    acc(16'h03F0, 1, 0);
    chk("R2 lower bound inclusive", card_hit, 1);
    acc(16'h03F6, 1, 0);
    chk("R2 upper bound inclusive", card_hit, 1);
    acc(16'h03EF, 1, 0);
    chk("R2 below lower bound", card_hit, 0);
    acc(16'h03F8, 1, 0);
    chk("R2 above single address", card_hit, 0);
    acc(16'h03F3, 0, 0);
    chk("R9 no strobe no hit", card_hit, 0);
    chk("R9 no strobe no drive", host_rdata_oe, 16'h0000);
    acc(16'h03F7, 0, 1);
    chk("R10 narrow write enables", card_wdata_oe, 16'h00FF);
    chk("R10 write data passes", card_wdata, host_wdata);
    chk("R10 no read drive on write", host_rdata_oe, 16'h0000);
    acc(16'h03F3, 0, 1);
    chk("R10 full write enables", card_wdata_oe, 16'hFFFF);

    // overlap: window 1 covers 3F0h..3FFh with mask 0Fh
    cfg(3'd3, 16'h03FF); cfg(3'd5, 16'h000F);
    acc(16'h03F7, 1, 0);
    chk("R7 window 0 governs overlap", host_rdata_oe, 16'h0080);
    acc(16'h03F8, 1, 0);
    chk("R8 window 1 own mask", host_rdata_oe, 16'h00F0);
    chk("R6 window 1 force", force_8bit, 1);
    cfg(3'd6, 16'h0002);
    acc(16'h03F7, 1, 0);
    chk("R3 window 0 disabled, window 1 governs", host_rdata_oe, 16'h00F0);
    cfg(3'd6, 16'h0001); cfg(3'd4, 16'h0000);
    acc(16'h03F7, 1, 0);
    chk("R11 mask cleared full width", host_rdata_oe, 16'hFFFF);
    chk("R5 cleared mask no force", force_8bit, 0);

    // sweep across both windows with all enables and strobe mixes
    cfg(3'd6, 16'h0003); cfg(3'd4, 16'h0055);
    for (int a = 16'h03E8; a < 16'h0408; a++) begin
      acc(16'(a), a[0], a[1]);
      @(posedge clk);
    end

    // a configuration write with cfg_we low must leave mask 0 untouched
    @(negedge clk); cfg_sel = 3'd4; cfg_wdata = 16'h0000;
    acc(16'h03F7, 1, 0);
    chk("R11 no write without strobe", host_rdata_oe, 16'h00AA);

    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule